// File: doc/BRIEF.md
# Serial Memory Read Front End

This block is the slave side of a three-wire serial memory interface with a chip select and an optional protect-select input. While chip select is high, it samples a command frame on the serial input at each rising serial-clock edge. The frame is a start bit, a two-bit opcode and a word address. A read request fetches the addressed 16-bit word through a synchronous read port. The block then sends a single zero bit followed by the word, most significant bit first. If chip select stays high, the following words stream out with no gap and no further zero bit. The address wraps from the top of the array back to zero.

With the protect-select input high, a read request returns the contents of the protect register instead of an array word. Write, erase and the extended commands are not executed here. They are decoded and handed onward as a one-cycle strobe with a command kind, the address and the protect-select flag.

The sequencer runs on the serial clock and has seven states. IDLE waits for the start bit: a 1 on DI goes to OPCODE, a 0 stays in IDLE. OPCODE takes two bits and goes to ADDRESS. ADDRESS takes AW bits, then goes to DUMMY for a read or to HOLD for any other command. DUMMY drives the zero bit, loads the shifter and goes to STREAM for an array read or PROTECT for a protect read. STREAM loops on itself and reloads every 16 bits. PROTECT goes to HOLD after PW bits. HOLD stays put. From any state, chip select low at a clock edge returns the sequencer to IDLE.

Top module: `uwire_rd_front`

## Requirements
- R1: Serial input is sampled on rising serial-clock edges while chip select is high. Zeros before the start bit (a 1) are ignored. Two opcode bits follow, MSB first, then AW address bits, MSB first.
- R2: For opcode 2'b10 with protect-select low at the last address edge, the output is enabled and drives 0 for one cycle. The addressed 16-bit word then follows MSB first, changing at each rising edge.
- R3: While chip select stays high, the word at the next address follows bit 0 immediately, with no zero bit in between.
- R4: The streaming address wraps from 2^AW-1 to 0.
- R5: For opcode 2'b10 with protect-select high at the last address edge, the output drives one 0 and then the PW-bit protect value MSB first, with no array read. After that the output is disabled and reads 1.
- R6: With protect-select low, a read always returns array data, even at an address that equals the protect value.
- R7: While chip select is low, the output enable is 0 and the data output is 1. A low chip select at any edge aborts the frame, and the next frame decodes from scratch.
- R8: Every command other than a read pulses cmd_stb_o for exactly one cycle after the last address edge, and the data output stays 1. The strobe carries cmd_addr_o and cmd_pre_o (protect-select at decode) and a kind code:
  - opcode 01: WRITE=1.
  - opcode 11: ERASE=2.
  - opcode 00: the top two address bits select the kind. 11 gives WEN=3, 00 gives WDS=4, 01 gives WRALL=5 and 10 gives ERAL=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sk_i | input | 1 | Serial clock |
| cs_i | input | 1 | Chip select, active high |
| di_i | input | 1 | Serial data in |
| pre_i | input | 1 | Protect-register select |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for do_o |
| mem_rd_o | output | 1 | Array read strobe, sampled by the array at the next rising edge |
| mem_addr_o | output | AW | Array read address |
| mem_rdata_i | input | DW | Array read data, registered by the array |
| prot_addr_i | input | PW | Protect register contents |
| cmd_stb_o | output | 1 | Non-read command strobe |
| cmd_kind_o | output | 3 | Command kind code |
| cmd_addr_o | output | AW | Command address |
| cmd_pre_o | output | 1 | Protect-select captured at decode |

## Verification
The assertions check the following on every cycle:
- A read decode is followed by a zero on the output.
- Chip select low always brings the sequencer back to IDLE.
- The command strobe never lasts more than one cycle.
- Each word boundary in STREAM advances the address by one modulo the array size, and the array was read one cycle before the boundary.
- The array is never read while the protect value is shifting.
- A loaded word's top bit appears on the output.

Only the bench scenarios can show the rest:
- The actual bit streams against the addressed contents.
- Leading-zero tolerance.
- The address wrap across a word boundary.
- The protect value and its trailing idle level.
- Command kind codes.
- Recovery after a frame is cut off mid-word.

// File: rtl/uwire_rd_pkg.sv
package uwire_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_STREAM,
        ST_PROT,
        ST_HOLD
    } fr_state_t;

    typedef enum logic [2:0] {
        CK_NONE  = 3'd0,
        CK_WRITE = 3'd1,
        CK_ERASE = 3'd2,
        CK_WEN   = 3'd3,
        CK_WDS   = 3'd4,
        CK_WRALL = 3'd5,
        CK_ERAL  = 3'd6
    } cmd_kind_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_WDS   = 2'b00;
    localparam logic [1:0] SUB_WRALL = 2'b01;
    localparam logic [1:0] SUB_ERAL  = 2'b10;
    localparam logic [1:0] SUB_WEN   = 2'b11;

endpackage

// File: rtl/uwire_cmd_decode.sv
module uwire_cmd_decode
    import uwire_rd_pkg::*;
(
    input  logic [1:0] opc_i,
    input  logic [1:0] sub_i,
    input  logic       pre_i,
    output logic       rd_array_o,
    output logic       rd_prot_o,
    output cmd_kind_t  kind_o
);

    always_comb begin
        rd_array_o = 1'b0;
        rd_prot_o  = 1'b0;
        kind_o     = CK_NONE;
        unique case (opc_i)
            OP_READ: begin
                rd_array_o = !pre_i;
                rd_prot_o  = pre_i;
            end
            OP_WRITE: kind_o = CK_WRITE;
            OP_ERASE: kind_o = CK_ERASE;
            OP_EXT: begin
                unique case (sub_i)
                    SUB_WEN:   kind_o = CK_WEN;
                    SUB_WDS:   kind_o = CK_WDS;
                    SUB_WRALL: kind_o = CK_WRALL;
                    SUB_ERAL:  kind_o = CK_ERAL;
                    default:   kind_o = CK_NONE;
                endcase
            end
            default: kind_o = CK_NONE;
        endcase
    end

endmodule

// File: rtl/uwire_sout_shift.sv
module uwire_sout_shift #(
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          shift_i,
    input  logic [DW-1:0] val_i,
    output logic          msb_o
);

    logic [DW-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= val_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[DW-2:0], 1'b0};
        end
    end

    assign msb_o = sh_q[DW-1];

    // R2: a loaded word presents its top bit first
    a_r2_load_msb: assert property (@(posedge clk_i) disable iff (!rst_n)
        load_i |=> (msb_o == $past(val_i[DW-1])));

endmodule

// File: rtl/uwire_rd_front.sv
module uwire_rd_front
    import uwire_rd_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int PW = AW
) (
    input  logic          rst_n,
    input  logic          sk_i,
    input  logic          cs_i,
    input  logic          di_i,
    input  logic          pre_i,
    output logic          do_o,
    output logic          do_oe_o,
    output logic          mem_rd_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic [PW-1:0] prot_addr_i,
    output logic          cmd_stb_o,
    output logic [2:0]    cmd_kind_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic          cmd_pre_o
);

    localparam int            CW        = $clog2(DW) + 1;
    localparam int            PSH       = DW - PW;
    localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] WORD_LAST = CW'(DW - 1);
    localparam logic [CW-1:0] WORD_PRE  = CW'(DW - 2);
    localparam logic [CW-1:0] PROT_LAST = CW'(PW - 1);
    localparam logic [CW-1:0] OPC_LAST  = CW'(1);

    fr_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [1:0]    opc_q;
    logic [AW-1:0] addr_sh_q;
    logic [AW-1:0] word_q;
    logic          prot_sel_q;
    logic          cmd_stb_q;
    cmd_kind_t     cmd_kind_q;
    logic [AW-1:0] cmd_addr_q;
    logic          cmd_pre_q;

    logic [AW-1:0] full_addr;
    logic          addr_done;
    logic          word_end;
    logic          rd_array, rd_prot;
    cmd_kind_t     dec_kind;
    logic          sh_load, sh_shift, sh_msb;
    logic [DW-1:0] sh_val;

    assign full_addr = {addr_sh_q[AW-2:0], di_i};
    assign addr_done = (state_q == ST_ADDR) && (cnt_q == ADDR_LAST);
    assign word_end  = (state_q == ST_STREAM) && (cnt_q == WORD_LAST);

    uwire_cmd_decode u_dec (
        .opc_i      (opc_q),
        .sub_i      (full_addr[AW-1:AW-2]),
        .pre_i      (pre_i),
        .rd_array_o (rd_array),
        .rd_prot_o  (rd_prot),
        .kind_o     (dec_kind)
    );

    // State register
    always_ff @(posedge sk_i or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (di_i) state_d = ST_OPC;
                ST_OPC:    if (cnt_q == OPC_LAST) state_d = ST_ADDR;
                ST_ADDR:   if (addr_done) state_d = (rd_array || rd_prot) ? ST_DUMMY : ST_HOLD;
                ST_DUMMY:  state_d = prot_sel_q ? ST_PROT : ST_STREAM;
                ST_STREAM: state_d = ST_STREAM;
                ST_PROT:   if (cnt_q == PROT_LAST) state_d = ST_HOLD;
                ST_HOLD:   state_d = ST_HOLD;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge sk_i or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            opc_q      <= '0;
            addr_sh_q  <= '0;
            word_q     <= '0;
            prot_sel_q <= 1'b0;
            cmd_stb_q  <= 1'b0;
            cmd_kind_q <= CK_NONE;
            cmd_addr_q <= '0;
            cmd_pre_q  <= 1'b0;
        end else begin
            cmd_stb_q <= 1'b0;
            if (!cs_i) begin
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: cnt_q <= '0;
                    ST_OPC: begin
                        opc_q <= {opc_q[0], di_i};
                        cnt_q <= (cnt_q == OPC_LAST) ? '0 : cnt_q + 1'b1;
                    end
                    ST_ADDR: begin
                        addr_sh_q <= full_addr;
                        cnt_q     <= addr_done ? '0 : cnt_q + 1'b1;
                        if (addr_done) begin
                            word_q     <= full_addr;
                            prot_sel_q <= rd_prot;
                            if (!(rd_array || rd_prot)) begin
                                cmd_stb_q  <= 1'b1;
                                cmd_kind_q <= dec_kind;
                                cmd_addr_q <= full_addr;
                                cmd_pre_q  <= pre_i;
                            end
                        end
                    end
                    ST_DUMMY: cnt_q <= '0;
                    ST_STREAM: begin
                        if (word_end) begin
                            cnt_q  <= '0;
                            word_q <= word_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_PROT: cnt_q <= cnt_q + 1'b1;
                    ST_HOLD: cnt_q <= cnt_q;
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    uwire_sout_shift #(.DW(DW)) u_shift (
        .clk_i   (sk_i),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .val_i   (sh_val),
        .msb_o   (sh_msb)
    );

    // Outputs
    always_comb begin
        sh_load    = cs_i && ((state_q == ST_DUMMY) || word_end);
        sh_shift   = cs_i && ((state_q == ST_STREAM) || (state_q == ST_PROT));
        sh_val     = (state_q == ST_DUMMY && prot_sel_q) ? (DW'(prot_addr_i) << PSH) : mem_rdata_i;
        mem_rd_o   = cs_i && ((addr_done && rd_array) ||
                              ((state_q == ST_STREAM) && (cnt_q == WORD_PRE)));
        mem_addr_o = addr_done ? full_addr : word_q + 1'b1;
        do_oe_o    = cs_i && ((state_q == ST_DUMMY) || (state_q == ST_STREAM) ||
                              (state_q == ST_PROT));
        if (!do_oe_o)                do_o = 1'b1;
        else if (state_q == ST_DUMMY) do_o = 1'b0;
        else                          do_o = sh_msb;
    end

    assign cmd_stb_o  = cmd_stb_q;
    assign cmd_kind_o = cmd_kind_q;
    assign cmd_addr_o = cmd_addr_q;
    assign cmd_pre_o  = cmd_pre_q;

    // R2: a decoded array read is followed by a zero bit
    a_r2_dummy_zero: assert property (@(posedge sk_i) disable iff (!rst_n)
        (addr_done && rd_array && cs_i) |=> (!cs_i || !do_o));

    // R7: chip select low returns the sequencer to IDLE
    a_r7_cs_idle: assert property (@(posedge sk_i) disable iff (!rst_n)
        !cs_i |=> (state_q == ST_IDLE));

    // R8: the command strobe lasts one cycle
    a_r8_stb_pulse: assert property (@(posedge sk_i) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o);

    // R3, R4: word boundary advances the address modulo the array size
    a_r3_addr_step: assert property (@(posedge sk_i) disable iff (!rst_n)
        (word_end && cs_i) |=> (word_q == AW'($past(word_q) + 1'b1)));

    // R3: the next word was fetched one cycle before the boundary
    a_r3_fetch_ahead: assert property (@(posedge sk_i) disable iff (!rst_n)
        (word_end && cs_i) |-> $past(mem_rd_o));

    // R5: no array access while the protect value shifts out
    a_r5_no_array: assert property (@(posedge sk_i) disable iff (!rst_n)
        (state_q == ST_PROT) |-> !mem_rd_o);

endmodule

// File: tb/uwire_rd_front_bench.sv
`timescale 1ns/1ps
module uwire_rd_front_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int PW = 6;
    localparam logic [PW-1:0] PROT_VAL = 6'h2D;

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic          pre;
        logic [1:0]    nw;
        logic [2:0]    kind;
        logic [1:0]    lead;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 6'h05, 1'b0, 2'd1, 3'd0, 2'd0},
        '{2'b10, 6'h3E, 1'b0, 2'd3, 3'd0, 2'd0},
        '{2'b10, 6'h20, 1'b1, 2'd0, 3'd0, 2'd0},
        '{2'b10, 6'h2D, 1'b0, 2'd1, 3'd0, 2'd0},
        '{2'b10, 6'h09, 1'b0, 2'd2, 3'd0, 2'd3},
        '{2'b01, 6'h12, 1'b0, 2'd0, 3'd1, 2'd0},
        '{2'b11, 6'h07, 1'b1, 2'd0, 3'd2, 2'd0},
        '{2'b00, 6'h30, 1'b0, 2'd0, 3'd3, 2'd1},
        '{2'b00, 6'h00, 1'b0, 2'd0, 3'd4, 2'd0},
        '{2'b00, 6'h10, 1'b0, 2'd0, 3'd5, 2'd0},
        '{2'b00, 6'h2A, 1'b1, 2'd0, 3'd6, 2'd0}
    };

    logic sk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, di = 1'b0, pre = 1'b0;
    logic do_w, do_oe, mem_rd, cmd_stb, cmd_pre;
    logic [AW-1:0] mem_addr, cmd_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic [2:0] cmd_kind;
    int checks = 0, errors = 0, rd_cnt = 0;
    bit done = 1'b0;

    always #2 sk = ~sk;

    uwire_rd_front u_uwire_rd_front (
        .rst_n(rst_n), .sk_i(sk), .cs_i(cs), .di_i(di), .pre_i(pre),
        .do_o(do_w), .do_oe_o(do_oe), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .prot_addr_i(PROT_VAL), .cmd_stb_o(cmd_stb),
        .cmd_kind_o(cmd_kind), .cmd_addr_o(cmd_addr), .cmd_pre_o(cmd_pre)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return 16'hC35A ^ {a, 4'h0, a};
    endfunction

    always_ff @(posedge sk) begin
        if (mem_rd) mem_rdata <= word_of(mem_addr);
        if (mem_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(input vec_t v, input int cut);
        logic [DW-1:0] w;
        logic [AW-1:0] a;
        int base;
        string tag;
        @(negedge sk); cs = 1'b1; pre = v.pre; di = 1'b0;
        repeat (int'(v.lead)) @(negedge sk);
        @(negedge sk); di = 1'b1;
        @(negedge sk); di = v.op[1];
        @(negedge sk); di = v.op[0];
        base = rd_cnt;
        for (int i = AW - 1; i >= 0; i--) begin
            @(negedge sk); di = v.addr[i];
        end
        @(negedge sk); di = 1'b0;
        if (v.op == 2'b10 && !v.pre) begin
            chk(do_oe && !do_w, "R2 dummy", {30'd0, do_oe, do_w}, 32'h2);
            for (int k = 0; k < int'(v.nw); k++) begin
                w = '0;
                a = AW'(v.addr + k);
                for (int b = 0; b < DW; b++) begin
                    if (cut > 0 && b == cut) break;
                    @(negedge sk); w = {w[DW-2:0], do_w};
                end
                if (cut > 0) break;
                if (v.lead != 0)                   tag = "R1 frame after leading zeros";
                else if (k == 0 && v.addr == 6'h2D) tag = "R6 array read at protect value";
                else if (k == 0)                   tag = "R2 first word";
                else if (a < v.addr)               tag = "R4 wrapped word";
                else                               tag = "R3 streamed word";
                chk(w == word_of(a), tag, {16'd0, w}, {16'd0, word_of(a)});
            end
        end else if (v.op == 2'b10) begin
            chk(do_oe && !do_w, "R5 dummy", {30'd0, do_oe, do_w}, 32'h2);
            w = '0;
            for (int b = 0; b < PW; b++) begin
                @(negedge sk); w = {w[DW-2:0], do_w};
            end
            chk(w[PW-1:0] == PROT_VAL, "R5 protect value", {26'd0, w[PW-1:0]}, {26'd0, PROT_VAL});
            @(negedge sk);
            chk(do_w && !do_oe, "R5 idle after value", {30'd0, do_oe, do_w}, 32'h1);
            chk(rd_cnt == base, "R5 no array read", rd_cnt - base, 32'd0);
        end else begin
            chk(cmd_stb && do_w, "R8 strobe", {30'd0, cmd_stb, do_w}, 32'h3);
            chk(cmd_kind == v.kind, "R8 kind", {29'd0, cmd_kind}, {29'd0, v.kind});
            chk(cmd_addr == v.addr && cmd_pre == v.pre, "R8 addr/pre",
                {25'd0, cmd_pre, cmd_addr}, {25'd0, v.pre, v.addr});
            @(negedge sk);
            chk(!cmd_stb, "R8 single pulse", {31'd0, cmd_stb}, 32'd0);
        end
        cs = 1'b0; di = 1'b0; pre = 1'b0;
        #1;
        chk(!do_oe && do_w, "R7 cs low", {30'd0, do_oe, do_w}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge sk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge sk);
        rst_n = 1'b1;
        @(negedge sk);
        // R7: reset and idle state
        chk(!do_oe && do_w, "R7 reset output", {30'd0, do_oe, do_w}, 32'h1);
        chk(!cmd_stb && !mem_rd, "R8 reset strobe", {30'd0, cmd_stb, mem_rd}, 32'h0);
        for (int n = 0; n < NV; n++) run_frame(VECS[n], 0);
        // R7: read aborted mid-word, then a fresh frame decodes correctly
        run_frame('{2'b10, 6'h11, 1'b0, 2'd1, 3'd0, 2'd0}, 5);
        run_frame('{2'b10, 6'h22, 1'b0, 2'd2, 3'd0, 2'd0}, 0);
        // R4: wrap from the last word straight into word zero
        run_frame('{2'b10, 6'h3F, 1'b0, 2'd2, 3'd0, 2'd0}, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule